// File: doc/BRIEF.md
# DMA Channel Transfer Progress Tracker

This block follows the progress of a single DMA channel. Software loads a start source address, a start destination address, a transfer count and a control word through a small register port. The control word selects the unit size, an address mode for each side and the interrupt enables. Setting the enable bit starts a run. Each time the bus side reports a finished unit on a one-cycle done strobe, the block moves both addresses by the unit size, as the side's mode directs, and lowers the remaining count by one.

The block keeps two sticky flags. The half-end flag sets once, when the remaining count falls to half of the count that was loaded at the start of the run. The end flag sets when the count runs out. When the end flag sets, the channel enable clears, and later done strobes do nothing. Each flag drives the single interrupt output when its enable bit is set. Software clears a flag by writing zero to it.

Top module: `dma_xfer_tracker`

## Requirements
- R1: After reset, all four registers read zero, the address outputs are zero and the interrupt output is low.
- R2: Register offsets are as follows: 0 is the source address, 1 is the destination address, 2 is the count (bits 23:0), and 3 is control. Control bits are: bit 0 enable, bits 2:1 unit size, bits 4:3 source mode, bits 6:5 destination mode, bit 7 half-interrupt enable, bit 8 end-interrupt enable, bit 9 half-end flag and bit 10 end flag. Every register reads back what was written, with unused bits reading zero.
- R3: Each done strobe that arrives while the channel is enabled lowers the count by exactly one by the next cycle.
- R4: In incrementing mode (code 0), an address advances by 1, 2, 4 or 16 bytes per unit for size codes 0, 1, 2 and 3.
- R5: Mode code 1 decrements an address by the unit size. Codes 2 and 3 hold the address fixed. Each side follows its own mode.
- R6: A loaded count of zero means 16,777,216 transfers. The first strobe leaves 0xFFFFFF and sets no flag.
- R7: At enable, the count is latched. The half-end flag sets exactly once per run, on the strobe after which the remaining count equals that latched count (zero taken as 2^24) shifted right by one.
- R8: The strobe that takes the count from one to zero sets the end flag and clears enable. Later strobes leave the count and both addresses unchanged.
- R9: The interrupt is high exactly when a flag is set together with its enable bit. Flags stay set until software writes 0 to the flag bit. Writing 1 to a flag bit leaves it unchanged.
- R10: With a loaded count of one, the half-end flag and the end flag set on the same strobe.
- R11: A done strobe while the channel is disabled changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational on regAddr) |
| xferDone | input | 1 | One unit finished on the bus side |
| srcAddrOut | output | 32 | Current source address |
| dstAddrOut | output | 32 | Current destination address |
| irqOut | output | 1 | Interrupt request |

## Verification
The half-end event and the end event can fall on the same strobe. This happens whenever the loaded count is one, because the half point is then zero. A directed run loads a count of one with both interrupt enables set and issues one strobe. The bench then expects both flag bits, the cleared enable and a high interrupt together in the control read-back. Random runs with small odd and even counts check that the half-end flag lands on the right strobe, and that it sets only once even when it is close to the end event.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int CTRL_W    = 11;
  localparam int B_EN      = 0;
  localparam int B_SIZE    = 1;
  localparam int B_SMODE   = 3;
  localparam int B_DMODE   = 5;
  localparam int B_HALF_IE = 7;
  localparam int B_END_IE  = 8;
  localparam int B_HALF_F  = 9;
  localparam int B_END_F   = 10;

  localparam logic [1:0] MODE_INC = 2'd0;
  localparam logic [1:0] MODE_DEC = 2'd1;

  typedef struct packed {
    logic       advance;
    logic       ldSrc;
    logic       ldDst;
    logic       ldCnt;
    logic       latchInit;
    logic [1:0] unitSize;
    logic [1:0] srcMode;
    logic [1:0] dstMode;
  } dpStrobe_t;

  function automatic logic [4:0] unitBytes(input logic [1:0] sz);
    case (sz)
      2'd0:    unitBytes = 5'd1;
      2'd1:    unitBytes = 5'd2;
      2'd2:    unitBytes = 5'd4;
      default: unitBytes = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_trk_datapath.sv
module dma_trk_datapath
  import dma_trk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  count,
  output logic              halfHit,
  output logic              lastHit
);

  localparam int EFF_W = CNT_W + 1;

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  initQ;
  logic [EFF_W-1:0]  cntEff;
  logic [EFF_W-1:0]  initEff;
  logic [EFF_W-1:0]  remNext;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] addrQ [2];

  // zero encodes the full 2^CNT_W range by supplying the extra top bit
  assign cntEff  = {(cntQ == '0), cntQ};
  assign initEff = {(initQ == '0), initQ};
  assign remNext = cntEff - EFF_W'(1);
  assign halfHit = (remNext == (initEff >> 1));
  assign lastHit = (cntQ == CNT_W'(1));
  assign stepVal = ADDR_W'(unitBytes(strb.unitSize));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      initQ <= '0;
    end else begin
      if (strb.ldCnt)        cntQ <= wrData[CNT_W-1:0];
      else if (strb.advance) cntQ <= cntQ - CNT_W'(1);
      if (strb.latchInit)    initQ <= cntQ;
    end
  end

  for (genvar side = 0; side < 2; side++) begin : g_side
    logic [1:0] sideMode;
    logic       sideLd;
    assign sideMode = (side == 0) ? strb.srcMode : strb.dstMode;
    assign sideLd   = (side == 0) ? strb.ldSrc   : strb.ldDst;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ[side] <= '0;
      end else if (sideLd) begin
        addrQ[side] <= wrData;
      end else if (strb.advance) begin
        case (sideMode)
          MODE_INC: addrQ[side] <= addrQ[side] + stepVal;
          MODE_DEC: addrQ[side] <= addrQ[side] - stepVal;
          default:  addrQ[side] <= addrQ[side];
        endcase
      end
    end
  end

  assign srcAddr = addrQ[0];
  assign dstAddr = addrQ[1];
  assign count   = cntQ;

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.ldCnt) |=> (cntQ == $past(cntQ) - CNT_W'(1)))
    else $error("count did not step by one");

  // R11
  src_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.ldSrc) |=> $stable(addrQ[0]))
    else $error("source address moved while idle");

  // R11
  dst_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.ldDst) |=> $stable(addrQ[1]))
    else $error("destination address moved while idle");

endmodule

// File: rtl/dma_trk_ctrl.sv
module dma_trk_ctrl
  import dma_trk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [CTRL_W-1:0] wrBits,
  input  logic              xferDone,
  input  logic              halfHit,
  input  logic              lastHit,
  output dpStrobe_t         strb,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              irqOut
);

  logic       enQ, hieQ, eieQ, halfQ, endQ, halfSeenQ;
  logic [1:0] sizeQ, smQ, dmQ;
  logic       wrCtrl, adv, halfEv, endEv, startRun;

  assign wrCtrl   = regWe && (regAddr == REG_CTRL);
  assign adv      = xferDone && enQ;
  assign halfEv   = adv && halfHit && !halfSeenQ;
  assign endEv    = adv && lastHit;
  assign startRun = wrCtrl && wrBits[B_EN] && !enQ;

  always_comb begin
    strb.advance   = adv;
    strb.ldSrc     = regWe && (regAddr == REG_SRC);
    strb.ldDst     = regWe && (regAddr == REG_DST);
    strb.ldCnt     = regWe && (regAddr == REG_CNT);
    strb.latchInit = startRun;
    strb.unitSize  = sizeQ;
    strb.srcMode   = smQ;
    strb.dstMode   = dmQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ <= 1'b0; hieQ <= 1'b0; eieQ <= 1'b0;
      halfQ <= 1'b0; endQ <= 1'b0; halfSeenQ <= 1'b0;
      sizeQ <= '0; smQ <= '0; dmQ <= '0;
    end else begin
      if (wrCtrl) begin
        enQ   <= wrBits[B_EN];
        sizeQ <= wrBits[B_SIZE +: 2];
        smQ   <= wrBits[B_SMODE +: 2];
        dmQ   <= wrBits[B_DMODE +: 2];
        hieQ  <= wrBits[B_HALF_IE];
        eieQ  <= wrBits[B_END_IE];
        halfQ <= halfQ & wrBits[B_HALF_F];
        endQ  <= endQ & wrBits[B_END_F];
      end
      if (startRun)    halfSeenQ <= 1'b0;
      else if (halfEv) halfSeenQ <= 1'b1;
      // hardware events win over a software clear in the same cycle
      if (halfEv) halfQ <= 1'b1;
      if (endEv) begin
        endQ <= 1'b1;
        enQ  <= 1'b0;
      end
    end
  end

  assign irqOut   = (halfQ && hieQ) || (endQ && eieQ);
  assign ctrlWord = {endQ, halfQ, eieQ, hieQ, dmQ, smQ, sizeQ, enQ};

  // R8
  end_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adv && lastHit) |=> (!enQ && endQ))
    else $error("end did not stop the channel");

  // R7
  half_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halfQ) |-> $past(adv))
    else $error("half flag rose without a transfer");

  // R7
  half_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfSeenQ && !startRun) |=> !$rose(halfQ))
    else $error("half flag set twice in a run");

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (halfQ || endQ))
    else $error("interrupt without a flag");

endmodule

// File: rtl/dma_xfer_tracker.sv
module dma_xfer_tracker
  import dma_trk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              xferDone,
  output logic [ADDR_W-1:0] srcAddrOut,
  output logic [ADDR_W-1:0] dstAddrOut,
  output logic              irqOut
);

  dpStrobe_t         strb;
  logic [CNT_W-1:0]  count;
  logic [CTRL_W-1:0] ctrlWord;
  logic              halfHit, lastHit;

  dma_trk_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .wrBits   (regWrData[CTRL_W-1:0]),
    .xferDone (xferDone),
    .halfHit  (halfHit),
    .lastHit  (lastHit),
    .strb     (strb),
    .ctrlWord (ctrlWord),
    .irqOut   (irqOut)
  );

  dma_trk_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (regWrData),
    .srcAddr (srcAddrOut),
    .dstAddr (dstAddrOut),
    .count   (count),
    .halfHit (halfHit),
    .lastHit (lastHit)
  );

  always_comb begin
    case (regAddr)
      REG_SRC: regRdData = srcAddrOut;
      REG_DST: regRdData = dstAddrOut;
      REG_CNT: regRdData = ADDR_W'(count);
      default: regRdData = ADDR_W'(ctrlWord);
    endcase
  end

endmodule

// File: tb/test_dma_xfer_tracker.sv
`timescale 1ns/100ps
module test_dma_xfer_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic        xferDone = 1'b0;
  logic [31:0] regRdData, srcAddrOut, dstAddrOut;
  logic        irqOut;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [31:0] eSrc, eDst;
  logic [23:0] eCnt;
  logic [24:0] eInit;
  logic [1:0]  eSize, eSm, eDm;
  logic        eEn, eHie, eEie, eHalf, eEnd, eSeen;

  dma_xfer_tracker i_dma_xfer_tracker (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .xferDone(xferDone),
    .srcAddrOut(srcAddrOut), .dstAddrOut(dstAddrOut), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [31:0] stepOf(input logic [1:0] s);
    case (s)
      2'd0: return 32'd1;
      2'd1: return 32'd2;
      2'd2: return 32'd4;
      default: return 32'd16;
    endcase
  endfunction

  function automatic logic [31:0] nextA(input logic [31:0] a, input logic [1:0] m, input logic [1:0] s);
    if (m == 2'd0) return a + stepOf(s);
    if (m == 2'd1) return a - stepOf(s);
    return a;
  endfunction

  function automatic logic [24:0] effOf(input logic [23:0] c);
    return (c == 24'd0) ? 25'h1000000 : {1'b0, c};
  endfunction

  function automatic logic [31:0] ctrlVal(input logic en);
    return {21'd0, eEnd, eHalf, eEie, eHie, eDm, eSm, eSize, en};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] d;
    rd(2'd0, d); check({tag, " R4/R5 src reg"}, d, eSrc);
    rd(2'd1, d); check({tag, " R4/R5 dst reg"}, d, eDst);
    rd(2'd2, d); check({tag, " R3 count"}, d, {8'd0, eCnt});
    rd(2'd3, d); check({tag, " R7/R8 ctrl"}, d, ctrlVal(eEn));
    check({tag, " R4 srcOut"}, srcAddrOut, eSrc);
    check({tag, " R5 dstOut"}, dstAddrOut, eDst);
    check({tag, " R9 irq"}, {31'd0, irqOut}, {31'd0, (eHalf & eHie) | (eEnd & eEie)});
  endtask

  task automatic startRun(input logic [31:0] s, input logic [31:0] d, input logic [23:0] c,
                          input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                          input logic hie, input logic eie);
    wr(2'd0, s); wr(2'd1, d); wr(2'd2, {8'd0, c});
    eSrc = s; eDst = d; eCnt = c; eSize = sz; eSm = sm; eDm = dm;
    eHie = hie; eEie = eie; eHalf = 1'b0; eEnd = 1'b0;
    wr(2'd3, ctrlVal(1'b1));
    eEn = 1'b1; eInit = effOf(c); eSeen = 1'b0;
  endtask

  task automatic strobe(input string tag);
    logic [24:0] rem;
    @(negedge clk);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
    if (eEn) begin
      rem = effOf(eCnt) - 25'd1;
      eCnt = eCnt - 24'd1;
      eSrc = nextA(eSrc, eSm, eSize);
      eDst = nextA(eDst, eDm, eSize);
      if (rem == (eInit >> 1) && !eSeen) begin eHalf = 1'b1; eSeen = 1'b1; end
      if (rem == 25'd0) begin eEnd = 1'b1; eEn = 1'b0; end
    end
    checkAll(tag);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    eSrc = '0; eDst = '0; eCnt = '0; eInit = '0; eSize = '0; eSm = '0; eDm = '0;
    eEn = 0; eHie = 0; eEie = 0; eHalf = 0; eEnd = 0; eSeen = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkAll("R1 reset");

    // R2 register layout and read-back
    wr(2'd0, 32'h1000_0000); wr(2'd1, 32'h2000_0000); wr(2'd2, 32'hFFAB_CDEF);
    eSrc = 32'h1000_0000; eDst = 32'h2000_0000; eCnt = 24'hABCDEF;
    eSize = 2'd2; eSm = 2'd1; eDm = 2'd2; eHie = 1'b1; eEie = 1'b0;
    wr(2'd3, 32'hFFFF_F8CC & 32'h0000_00CC);
    rd(2'd3, d); check("R2 ctrl readback", d, 32'h0000_00CC);
    checkAll("R2 layout");

    // R11 strobe while disabled
    strobe("R11 disabled strobe");

    // R6 zero count means maximum
    startRun(32'h0000_0100, 32'h0000_0200, 24'd0, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1);
    strobe("R6 zero count");
    check("R6 no flags", {30'd0, eHalf, eEnd}, 32'd0);
    wr(2'd3, ctrlVal(1'b0)); eEn = 1'b0;

    // R10 count of one: both flags in one cycle
    startRun(32'h0000_4000, 32'h8000_0000, 24'd1, 2'd3, 2'd0, 2'd1, 1'b1, 1'b1);
    strobe("R10 single unit");
    rd(2'd3, d); check("R10 both flags", d & 32'h601, 32'h600);

    // R8 strobes after end are ignored
    strobe("R8 after end");
    strobe("R8 after end again");

    // R9 flag write semantics
    wr(2'd3, 32'h0000_0200 | ctrlVal(1'b0) & 32'h0000_01FE); eEnd = 1'b0;
    checkAll("R9 clear end keep half");
    check("R9 irq from half", {31'd0, irqOut}, 32'd1);
    wr(2'd3, ctrlVal(1'b0) & 32'h0000_01FE); eHalf = 1'b0;
    checkAll("R9 all cleared");

    // random runs: R3 R4 R5 R7 R8 R9
    for (int run = 0; run < 30; run++) begin
      logic [23:0] c;
      c = 24'd1 + 24'($urandom % 40);
      startRun($urandom, $urandom, c, 2'($urandom), 2'($urandom), 2'($urandom),
               1'($urandom), 1'($urandom));
      for (int k = 0; k < int'(c) + 2; k++) begin
        strobe("rand R3/R4/R5/R7/R8");
        if ($urandom % 4 == 0) repeat (1 + $urandom % 3) @(negedge clk);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule